// File: doc/BRIEF.md
# Atomic Read-Modify-Write Memory Unit

This unit sits on the memory side of a small multi-core system and owns a shared, word-addressed store. Several requesters present operations on a shared request bus. A round-robin arbiter accepts one operation at a time. The unit serves plain loads and stores. It also serves three indivisible read-modify-write operations: test-and-set, fetch-and-add and compare-and-swap. Each one is built from a fixed read phase and an optional write phase. The write happens only when the operation's condition holds.

While an atomic operation is in flight, the unit raises a bus-lock output that models the locked coherence bus. The lock stays up even when the operation ends without a write, for example a test-and-set that finds the word already taken. A requester keeps its request raised until it sees its grant pulse. It then waits for its one-cycle response, which carries the word read and a status flag. Software builds spin locks on top of this: test-and-set acquires the lock and a plain store of zero releases it.

Top module: `atomic_rmw_unit`

## Requirements
- R1: Test-and-set (opcode 2) returns the word read. If that word is 0, the unit writes 1 and reports flag 1. Otherwise the word is left unchanged and the flag is 0.
- R2: Fetch-and-add (opcode 3) returns the previous word, stores the previous word plus operand A wrapped modulo 2^DATA_W, and reports flag 0.
- R3: Compare-and-swap (opcode 4) returns the previous word. It writes operand B and reports flag 1 only when the previous word equals operand A. Otherwise memory is left unchanged and the flag is 0.
- R4: Load (opcode 0) returns the word with flag 0. Store (opcode 1) writes operand A and returns the previous word with flag 0. Opcodes 5 to 7 behave as a load.
- R5: bus_lock is high on exactly the three cycles that follow the acceptance edge of an atomic operation, including the response cycle, whether or not a write occurs. It stays low for loads and stores.
- R6: At most one operation is accepted at a time. req_grant is a one-hot pulse on the accepting cycle. The response appears on the third cycle after the acceptance edge, and no grant is given before the cycle after the response. A request that is not granted stays pending and is served later.
- R7: Arbitration is round-robin. After reset, requester 0 has the highest priority. After requester k is granted, priority starts at k+1 modulo N_REQ.
- R8: Reset clears every memory word to 0, and leaves rsp_valid and bus_lock low.
- R9: When every requester issues test-and-set on the same free word at once, exactly one of them receives flag 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | N_REQ | Request pending, one bit per requester |
| req_op | input | 3*N_REQ | Opcode per requester (0 load, 1 store, 2 test-and-set, 3 fetch-and-add, 4 compare-and-swap) |
| req_addr | input | ADDR_W*N_REQ | Word address per requester |
| req_opa | input | DATA_W*N_REQ | Operand A: store data, increment or compare value |
| req_opb | input | DATA_W*N_REQ | Operand B: swap value |
| req_grant | output | N_REQ | One-hot acceptance pulse |
| rsp_valid | output | N_REQ | One-hot response strobe |
| rsp_data | output | DATA_W | Word value read before any write |
| rsp_flag | output | 1 | Zero flag for test-and-set, success for compare-and-swap, else 0 |
| bus_lock | output | 1 | Bus held by an atomic operation |

## Verification
The hardest situation to reach is a true race: several requesters reaching for one free lock word in the same cycle. In that case the arbiter alone decides the winner, and every loser must find the word already taken under the lock. The bench raises test-and-set on all requesters at the same clock edge. It keeps the losers' requests up while the lock is held, then checks three things: exactly one requester wins, the grants rotate in round-robin order, and the losers are served afterwards rather than dropped. The vector table builds lock acquire-and-release histories and wrapping additions, so each operation meets words left behind by earlier ones.

// File: rtl/amu_pkg.sv
package amu_pkg;

  localparam logic [2:0] OP_LOAD  = 3'd0;
  localparam logic [2:0] OP_STORE = 3'd1;
  localparam logic [2:0] OP_TAS   = 3'd2;
  localparam logic [2:0] OP_FAA   = 3'd3;
  localparam logic [2:0] OP_CAS   = 3'd4;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2,
    ST_RESP  = 2'd3
  } amu_state_e;

  function automatic logic is_atomic(input logic [2:0] op);
    return (op == OP_TAS) || (op == OP_FAA) || (op == OP_CAS);
  endfunction

endpackage

// File: rtl/amu_arbiter.sv
module amu_arbiter #(
  parameter int N  = 4,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic          en,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] gnt_idx,
  output logic          gnt_any
);

  logic [IW-1:0] ptr_q;

  always_comb begin
    int j;
    logic found;
    gnt     = '0;
    gnt_idx = '0;
    found   = 1'b0;
    for (int off = 0; off < N; off++) begin
      j = (int'(ptr_q) + off) % N;
      if (!found && req[j] && en) begin
        found    = 1'b1;
        gnt[j]   = 1'b1;
        gnt_idx  = IW'(j);
      end
    end
    gnt_any = found;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (gnt_any) begin
      ptr_q <= (gnt_idx == IW'(N - 1)) ? '0 : gnt_idx + IW'(1);
    end
  end

  p_grant_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));
  p_grant_in_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~req) == '0);

endmodule

// File: rtl/amu_mem.sv
module amu_mem #(
  parameter int DW = 32,
  parameter int AW = 6,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic          we,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data
);

  logic [DW-1:0] words_q [DEPTH];
  logic [DW-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) words_q[i] <= '0;
      rd_q <= '0;
    end else begin
      if (we) words_q[wr_addr] <= wr_data;
      rd_q <= words_q[rd_addr];
    end
  end

  assign rd_data = rd_q;

endmodule

// File: rtl/amu_seq.sv
module amu_seq
  import amu_pkg::*;
#(
  parameter int N  = 4,
  parameter int DW = 32,
  parameter int AW = 6,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            accept,
  input  logic [IW-1:0]   acc_idx,
  input  logic [3*N-1:0]  req_op,
  input  logic [AW*N-1:0] req_addr,
  input  logic [DW*N-1:0] req_opa,
  input  logic [DW*N-1:0] req_opb,
  output logic            idle,
  output logic [AW-1:0]   rd_addr,
  input  logic [DW-1:0]   rd_data,
  output logic            we,
  output logic [AW-1:0]   wa,
  output logic [DW-1:0]   wd,
  output logic [N-1:0]    rsp_valid,
  output logic [DW-1:0]   rsp_data,
  output logic            rsp_flag,
  output logic            bus_lock
);

  function automatic logic f_write_needed(input logic [2:0] op,
                                          input logic [DW-1:0] old,
                                          input logic [DW-1:0] a);
    case (op)
      OP_STORE: return 1'b1;
      OP_TAS:   return old == '0;
      OP_FAA:   return 1'b1;
      OP_CAS:   return old == a;
      default:  return 1'b0;
    endcase
  endfunction

  function automatic logic [DW-1:0] f_new_value(input logic [2:0] op,
                                                input logic [DW-1:0] old,
                                                input logic [DW-1:0] a,
                                                input logic [DW-1:0] b);
    case (op)
      OP_STORE: return a;
      OP_TAS:   return DW'(1);
      OP_FAA:   return old + a;
      OP_CAS:   return b;
      default:  return old;
    endcase
  endfunction

  function automatic logic f_flag(input logic [2:0] op,
                                  input logic [DW-1:0] old,
                                  input logic [DW-1:0] a);
    case (op)
      OP_TAS:  return old == '0;
      OP_CAS:  return old == a;
      default: return 1'b0;
    endcase
  endfunction

  amu_state_e    st_q;
  logic [2:0]    op_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] a_q, b_q, old_q, wval_q;
  logic [IW-1:0] own_q;
  logic          wen_q, flag_q, lock_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      op_q   <= OP_LOAD;
      addr_q <= '0;
      a_q    <= '0;
      b_q    <= '0;
      old_q  <= '0;
      wval_q <= '0;
      own_q  <= '0;
      wen_q  <= 1'b0;
      flag_q <= 1'b0;
      lock_q <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: if (accept) begin
          op_q   <= req_op[acc_idx*3 +: 3];
          addr_q <= req_addr[acc_idx*AW +: AW];
          a_q    <= req_opa[acc_idx*DW +: DW];
          b_q    <= req_opb[acc_idx*DW +: DW];
          own_q  <= acc_idx;
          lock_q <= is_atomic(req_op[acc_idx*3 +: 3]);
          st_q   <= ST_READ;
        end
        ST_READ: begin
          old_q  <= rd_data;
          wen_q  <= f_write_needed(op_q, rd_data, a_q);
          wval_q <= f_new_value(op_q, rd_data, a_q, b_q);
          flag_q <= f_flag(op_q, rd_data, a_q);
          st_q   <= ST_WRITE;
        end
        ST_WRITE: st_q <= ST_RESP;
        default: begin
          lock_q <= 1'b0;
          wen_q  <= 1'b0;
          st_q   <= ST_IDLE;
        end
      endcase
    end
  end

  assign idle     = (st_q == ST_IDLE);
  assign rd_addr  = req_addr[acc_idx*AW +: AW];
  assign we       = (st_q == ST_WRITE) && wen_q;
  assign wa       = addr_q;
  assign wd       = wval_q;
  assign rsp_data = old_q;
  assign rsp_flag = flag_q;
  assign bus_lock = lock_q;

  always_comb begin
    rsp_valid = '0;
    for (int i = 0; i < N; i++)
      if (st_q == ST_RESP && own_q == IW'(i)) rsp_valid[i] = 1'b1;
  end

  p_tas_write_cond_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (we && op_q == OP_TAS) |-> (old_q == '0 && wd == DW'(1)));
  p_cas_write_cond_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (we && op_q == OP_CAS) |-> (old_q == a_q));
  p_load_no_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_q == OP_LOAD) |-> !we);
  p_lock_until_rsp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_lock && st_q != ST_RESP) |=> bus_lock);
  p_lock_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RESP) |=> !bus_lock);

endmodule

// File: rtl/atomic_rmw_unit.sv
module atomic_rmw_unit #(
  parameter int N_REQ  = 4,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 6,
  localparam int IW = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_REQ-1:0]         req_valid,
  input  logic [3*N_REQ-1:0]       req_op,
  input  logic [ADDR_W*N_REQ-1:0]  req_addr,
  input  logic [DATA_W*N_REQ-1:0]  req_opa,
  input  logic [DATA_W*N_REQ-1:0]  req_opb,
  output logic [N_REQ-1:0]         req_grant,
  output logic [N_REQ-1:0]         rsp_valid,
  output logic [DATA_W-1:0]        rsp_data,
  output logic                     rsp_flag,
  output logic                     bus_lock
);

  logic              seq_idle, acc_any, mem_we;
  logic [IW-1:0]     acc_idx;
  logic [ADDR_W-1:0] mem_ra, mem_wa;
  logic [DATA_W-1:0] mem_rd, mem_wd;

  amu_arbiter #(.N(N_REQ), .IW(IW)) u_arb (
    .clk(clk), .rst_n(rst_n), .req(req_valid), .en(seq_idle),
    .gnt(req_grant), .gnt_idx(acc_idx), .gnt_any(acc_any)
  );

  amu_mem #(.DW(DATA_W), .AW(ADDR_W)) u_mem (
    .clk(clk), .rst_n(rst_n), .rd_addr(mem_ra), .rd_data(mem_rd),
    .we(mem_we), .wr_addr(mem_wa), .wr_data(mem_wd)
  );

  amu_seq #(.N(N_REQ), .DW(DATA_W), .AW(ADDR_W), .IW(IW)) u_seq (
    .clk(clk), .rst_n(rst_n), .accept(acc_any), .acc_idx(acc_idx),
    .req_op(req_op), .req_addr(req_addr), .req_opa(req_opa), .req_opb(req_opb),
    .idle(seq_idle), .rd_addr(mem_ra), .rd_data(mem_rd),
    .we(mem_we), .wa(mem_wa), .wd(mem_wd),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_flag(rsp_flag),
    .bus_lock(bus_lock)
  );

  p_no_grant_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_lock |-> (req_grant == '0));
  p_rsp_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rsp_valid));
  p_no_grant_with_rsp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid != '0) |-> (req_grant == '0));

endmodule

// File: tb/atomic_rmw_unit_test.sv
module atomic_rmw_unit_test;

  localparam int N = 4, DW = 32, AW = 6;

  typedef struct packed {
    logic [1:0]    rq;
    logic [2:0]    op;
    logic [AW-1:0] ad;
    logic [DW-1:0] a;
    logic [DW-1:0] b;
    logic [DW-1:0] ed;
    logic          ef;
  } vec_t;

  // Opcodes: 0 load, 1 store, 2 test-and-set, 3 fetch-and-add, 4 compare-and-swap
  localparam vec_t VT [17] = '{
    '{2'd0, 3'd2, 6'd5,  32'd0,        32'd0,  32'd0,  1'b1}, // R1 free lock
    '{2'd1, 3'd2, 6'd5,  32'd0,        32'd0,  32'd1,  1'b0}, // R1 taken lock
    '{2'd2, 3'd0, 6'd5,  32'd0,        32'd0,  32'd1,  1'b0}, // R4 load
    '{2'd3, 3'd1, 6'd5,  32'd0,        32'd0,  32'd1,  1'b0}, // R4 release store
    '{2'd1, 3'd2, 6'd5,  32'd0,        32'd0,  32'd0,  1'b1}, // R1 reacquire
    '{2'd0, 3'd3, 6'd9,  32'd7,        32'd0,  32'd0,  1'b0}, // R2
    '{2'd0, 3'd3, 6'd9,  32'hFFFFFFFF, 32'd0,  32'd7,  1'b0}, // R2 wrap
    '{2'd2, 3'd3, 6'd9,  32'hFFFFFFFA, 32'd0,  32'd6,  1'b0}, // R2 wrap to 0
    '{2'd2, 3'd0, 6'd9,  32'd0,        32'd0,  32'd0,  1'b0}, // R2 result
    '{2'd3, 3'd4, 6'd12, 32'd1,        32'd55, 32'd0,  1'b0}, // R3 mismatch
    '{2'd3, 3'd0, 6'd12, 32'd0,        32'd0,  32'd0,  1'b0}, // R3 unchanged
    '{2'd1, 3'd4, 6'd12, 32'd0,        32'd55, 32'd0,  1'b1}, // R3 match
    '{2'd0, 3'd0, 6'd12, 32'd0,        32'd0,  32'd55, 1'b0}, // R3 swapped
    '{2'd0, 3'd2, 6'd12, 32'd0,        32'd0,  32'd55, 1'b0}, // R1 nonzero word
    '{2'd0, 3'd0, 6'd12, 32'd0,        32'd0,  32'd55, 1'b0}, // R1 untouched
    '{2'd2, 3'd7, 6'd20, 32'd9,        32'd9,  32'd0,  1'b0}, // R4 opcode 7
    '{2'd2, 3'd0, 6'd20, 32'd0,        32'd0,  32'd0,  1'b0}  // R4 no write
  };

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic [N-1:0]       req_valid = '0;
  logic [3*N-1:0]     req_op = '0;
  logic [AW*N-1:0]    req_addr = '0;
  logic [DW*N-1:0]    req_opa = '0;
  logic [DW*N-1:0]    req_opb = '0;
  logic [N-1:0]       req_grant, rsp_valid;
  logic [DW-1:0]      rsp_data;
  logic               rsp_flag, bus_lock;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  atomic_rmw_unit #(.N_REQ(N), .DATA_W(DW), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_opa(req_opa), .req_opb(req_opb),
    .req_grant(req_grant), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .rsp_flag(rsp_flag), .bus_lock(bus_lock)
  );

  task automatic chk(input string rid, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", rid, act, exp);
    end
  endtask

  task automatic load_req(input int rq, input logic [2:0] op, input logic [AW-1:0] ad,
                          input logic [DW-1:0] a, input logic [DW-1:0] b);
    req_op[rq*3 +: 3]    = op;
    req_addr[rq*AW +: AW] = ad;
    req_opa[rq*DW +: DW]  = a;
    req_opb[rq*DW +: DW]  = b;
    req_valid[rq]         = 1'b1;
  endtask

  // waits for the response of rq after its acceptance edge
  task automatic wait_rsp(input int rq, output logic [DW-1:0] d, output logic f,
                          output int lat, output int lk);
    lat = 0;
    lk  = 0;
    do begin
      @(negedge clk);
      lat++;
      if (bus_lock) lk++;
    end while (!rsp_valid[rq] && lat < 20);
    d = rsp_data;
    f = rsp_flag;
  endtask

  task automatic run_op(input int rq, input logic [2:0] op, input logic [AW-1:0] ad,
                        input logic [DW-1:0] a, input logic [DW-1:0] b,
                        output logic [DW-1:0] d, output logic f,
                        output int lat, output int lk);
    @(negedge clk);
    load_req(rq, op, ad, a, b);
    #1;
    while (!req_grant[rq]) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1 req_valid[rq] = 1'b0;
    wait_rsp(rq, d, f, lat, lk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [DW-1:0] d;
    logic f;
    int lat, lk, first, wins;
    int order [4];

    repeat (3) @(negedge clk);
    chk("R8 rsp_valid in reset", DW'(rsp_valid), '0);
    chk("R8 bus_lock in reset", DW'(bus_lock), '0);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    chk("R8 rsp_valid after reset", DW'(rsp_valid), '0);
    chk("R8 bus_lock after reset", DW'(bus_lock), '0);

    // R7: priority starts at requester 0 after reset
    load_req(2, 3'd0, 6'd1, '0, '0);
    load_req(0, 3'd0, 6'd0, '0, '0);
    #1;
    first = -1;
    for (int i = 0; i < N; i++) if (req_grant[i]) first = i;
    chk("R7 first grant after reset", DW'(first), 32'd0);
    @(posedge clk);
    #1 req_valid[0] = 1'b0;
    wait_rsp(0, d, f, lat, lk);
    chk("R8 memory cleared", d, 32'd0);
    chk("R6 no grant to pending while busy", DW'(req_grant), '0);
    @(negedge clk);
    #1;
    chk("R6 pending request granted later", DW'(req_grant[2]), 32'd1);
    @(posedge clk);
    #1 req_valid[2] = 1'b0;
    wait_rsp(2, d, f, lat, lk);
    chk("R6 pending request served", DW'(lat), 32'd3);

    // vector table
    for (int v = 0; v < 17; v++) begin
      run_op(int'(VT[v].rq), VT[v].op, VT[v].ad, VT[v].a, VT[v].b, d, f, lat, lk);
      chk($sformatf("R1-4 vec%0d data", v), d, VT[v].ed);
      chk($sformatf("R1-4 vec%0d flag", v), DW'(f), DW'(VT[v].ef));
      chk($sformatf("R6 vec%0d latency", v), DW'(lat), 32'd3);
    end

    // R5: lock held on a test-and-set that does no write; none for load/store
    run_op(1, 3'd2, 6'd5, '0, '0, d, f, lat, lk);
    chk("R5 lock cycles tas no write", DW'(lk), 32'd3);
    chk("R5 lock high on response", DW'(bus_lock), 32'd1);
    @(negedge clk);
    chk("R5 lock low after response", DW'(bus_lock), 32'd0);
    run_op(3, 3'd1, 6'd5, 32'd0, '0, d, f, lat, lk);
    chk("R5 no lock for store", DW'(lk), 32'd0);
    run_op(0, 3'd3, 6'd40, 32'd2, '0, d, f, lat, lk);
    chk("R5 lock cycles faa", DW'(lk), 32'd3);

    // R9/R7: all requesters race for free word 30
    @(negedge clk);
    for (int i = 0; i < N; i++) load_req(i, 3'd2, 6'd30, '0, '0);
    wins = 0;
    for (int k = 0; k < N; k++) begin
      int g;
      #1;
      while (req_grant == '0) begin
        @(negedge clk);
        #1;
      end
      g = 0;
      for (int i = 0; i < N; i++) if (req_grant[i]) g = i;
      order[k] = g;
      @(posedge clk);
      #1 req_valid[g] = 1'b0;
      wait_rsp(g, d, f, lat, lk);
      if (f) wins++;
      @(negedge clk);
    end
    chk("R9 single winner", DW'(wins), 32'd1);
    for (int k = 0; k < N - 1; k++)
      chk("R7 rotation", DW'(order[k+1]), DW'((order[k] + 1) % N));
    run_op(1, 3'd0, 6'd30, '0, '0, d, f, lat, lk);
    chk("R9 word taken", d, 32'd1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule